// File: doc/BRIEF.md
# Triggered Descriptor-Chain Copy Engine

This block is a single memory-to-memory copy channel. It is driven by a list of descriptors that sit in ordinary memory. Software places the address of the first descriptor on `head_ptr`, picks one of the upstream completion lines with `req_sel`, and pulses `start`. From that point the channel needs no further help from a processor. Each rising edge on the selected line lets the engine fetch one descriptor and copy that descriptor's block from source to destination. The engine then writes a programmed mask to a programmed address, which clears the flag of the upstream channel that raised the request. After that it parks and waits for the next request.

The data is copied in chunks of up to `BURST_WORDS` words, which is 128 bytes at the default width. A chunk is first read into a local buffer and then written out, and both addresses step by one word per beat. A descriptor whose link word is zero ends the chain. A link that points back to an earlier descriptor makes the chain repeat for ever, and only `abort` stops it. The memory master is a plain request/ready port. A beat completes in any cycle in which `mem_req` and `mem_ready` are both high, and read data is taken from `mem_rdata` in that same cycle.

Top module: `dma_ll_engine`

## Requirements
- R1: After reset, `busy`, `mem_req`, `irq_node`, `irq_chain` and `aborted` are all 0.
- R2: After `start`, the engine issues no memory beat until the trigger line chosen by `req_sel` rises. Edges on any other trigger line have no effect.
- R3: A descriptor is fetched as six word reads at consecutive word addresses, starting at the descriptor address. The words are, in order: source address, destination address, byte length, acknowledge address, acknowledge mask and link pointer.
- R4: The block is moved as byte length / 4 words, and the two low bits of the length are ignored. The words move in chunks of at most `BURST_WORDS`. Each chunk is read from incrementing source addresses and then written to incrementing destination addresses with the same data.
- R5: After the last data write of a descriptor, the engine writes the acknowledge mask to the acknowledge address. This is the descriptor's final beat, and `irq_node` is set when it completes.
- R6: After a descriptor with a non-zero link, the engine stays busy and issues no memory beat until the next trigger event.
- R7: After a descriptor whose link is zero, the engine sets `irq_chain` and returns to idle with `busy` low.
- R8: A link that points back to an earlier descriptor repeats the chain indefinitely, with `busy` high and `irq_chain` never set.
- R9: A trigger edge that arrives while a descriptor is still in progress is held as pending. The next descriptor then starts without any further edge.
- R10: `abort` takes effect only at a beat boundary, never while a beat is waiting for `mem_ready`. The engine then goes idle, sets `aborted`, and issues no further beats.
- R11: A descriptor with a byte length below 4 performs no data beats. Only its acknowledge write is issued after the fetch.
- R12: `irq_clr` clears `irq_node` and `irq_chain`. A `start` clears all three status flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a chain at `head_ptr` (accepted only when idle) |
| abort | input | 1 | Stop the channel at the next beat boundary |
| irq_clr | input | 1 | Clear the node and chain flags |
| head_ptr | input | AW | Address of the first descriptor |
| req_sel | input | $clog2(NTRIG) | Which trigger line paces the chain |
| trig_in | input | NTRIG | Upstream transfer-complete lines |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | AW | Byte address of the beat |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_rdata | input | DW | Read data for an accepted read beat |
| busy | output | 1 | Channel is active |
| irq_node | output | 1 | A descriptor has completed (sticky) |
| irq_chain | output | 1 | A zero link ended the chain (sticky) |
| aborted | output | 1 | The channel was stopped by `abort` (sticky) |

## Verification
The bench builds the engine with `BURST_WORDS` set to 4 and `NTRIG` set to 8. With these values, blocks of only a few words already split into several full chunks plus a short remainder, so the chunk boundary and remainder handling can be exercised in short runs. A wrong choice of trigger line also becomes visible. A memory that stalls in a fixed pattern places aborts and pending triggers in the middle of a beat, where they must not take effect early.

// File: rtl/dma_ll_pkg.sv
`timescale 1ns/1ps
package dma_ll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_FETCH = 3'd2,
        ST_READ  = 3'd3,
        ST_WRITE = 3'd4,
        ST_ACK   = 3'd5
    } dma_state_e;

    // descriptor word positions, fixed by the fetch order (R3)
    localparam logic [2:0] FLD_SRC  = 3'd0;
    localparam logic [2:0] FLD_DST  = 3'd1;
    localparam logic [2:0] FLD_LEN  = 3'd2;
    localparam logic [2:0] FLD_AADR = 3'd3;
    localparam logic [2:0] FLD_AMSK = 3'd4;
    localparam logic [2:0] FLD_LINK = 3'd5;

endpackage

// File: rtl/dma_trig_sel.sv
`timescale 1ns/1ps
module dma_trig_sel #(
    parameter int unsigned NTRIG = 16,
    localparam int unsigned SW = $clog2(NTRIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig_in,
    input  logic [SW-1:0]    sel,
    input  logic             armed,
    input  logic             take,
    input  logic             flush,
    output logic             fire
);
    logic [NTRIG-1:0] prev_d, prev_q;
    logic             pend_d, pend_q;
    logic             rise;

    always_comb begin
        prev_d = trig_in;
        rise   = trig_in[sel] & ~prev_q[sel];
        fire   = armed & (pend_q | rise);
        pend_d = (pend_q | (armed & rise)) & ~take & ~flush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/dma_chunk_buf.sv
`timescale 1ns/1ps
module dma_chunk_buf #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == IW'(g))) begin
                slot_q[g] <= wdata;
            end
        end
    end

    always_comb rdata = slot_q[raddr];
endmodule

// File: rtl/dma_ll_engine.sv
`timescale 1ns/1ps
module dma_ll_engine
    import dma_ll_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned DW          = 32,
    parameter int unsigned NTRIG       = 16,
    parameter int unsigned BURST_WORDS = 32,
    localparam int unsigned SW         = $clog2(NTRIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             irq_clr,
    input  logic [AW-1:0]    head_ptr,
    input  logic [SW-1:0]    req_sel,
    input  logic [NTRIG-1:0] trig_in,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ready,
    input  logic [DW-1:0]    mem_rdata,
    output logic             busy,
    output logic             irq_node,
    output logic             irq_chain,
    output logic             aborted
);
    localparam int unsigned CW = $clog2(BURST_WORDS);
    localparam int unsigned LW = DW - 2;
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    typedef struct packed {
        dma_state_e    state;
        logic [AW-1:0] cur;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] ack_addr;
        logic [DW-1:0] ack_mask;
        logic [AW-1:0] link;
        logic [2:0]    fld;
        logic [LW-1:0] words;
        logic [CW:0]   beat;
        logic [CW:0]   chunk;
        logic          f_node;
        logic          f_chain;
        logic          f_abort;
        logic          abort_pend;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic          hs;
    logic          st_wait;
    logic          fire;
    logic          take;
    logic          flush;
    logic          buf_we;
    logic [DW-1:0] buf_rdata;

    function automatic logic [CW:0] chunk_of(input logic [LW-1:0] w);
        if (w > LW'(BURST_WORDS)) begin
            return (CW+1)'(BURST_WORDS);
        end
        return w[CW:0];
    endfunction

    // memory master outputs decoded from the registered state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (r_q.state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = r_q.cur + (AW'(r_q.fld) * STEP);
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = r_q.src;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.dst;
                mem_wdata = buf_rdata;
            end
            ST_ACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.ack_addr;
                mem_wdata = r_q.ack_mask;
            end
            default: ;
        endcase
    end

    assign hs      = mem_req & mem_ready;
    assign st_wait = (r_q.state == ST_WAIT);
    assign take    = st_wait & fire;
    assign flush   = (r_q.state == ST_IDLE) & start;
    assign buf_we  = (r_q.state == ST_READ) & hs;

    dma_trig_sel #(
        .NTRIG (NTRIG)
    ) i_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .sel     (req_sel),
        .armed   (busy),
        .take    (take),
        .flush   (flush),
        .fire    (fire)
    );

    dma_chunk_buf #(
        .DW    (DW),
        .DEPTH (BURST_WORDS)
    ) i_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (r_q.beat[CW-1:0]),
        .wdata (mem_rdata),
        .raddr (r_q.beat[CW-1:0]),
        .rdata (buf_rdata)
    );

    always_comb begin
        r_d = r_q;
        if (irq_clr) begin
            r_d.f_node  = 1'b0;
            r_d.f_chain = 1'b0;
        end
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state   = ST_WAIT;
                    r_d.cur     = head_ptr;
                    r_d.f_node  = 1'b0;
                    r_d.f_chain = 1'b0;
                    r_d.f_abort = 1'b0;
                end
            end
            ST_WAIT: begin
                if (fire) begin
                    r_d.state = ST_FETCH;
                    r_d.fld   = FLD_SRC;
                end
            end
            ST_FETCH: begin
                if (hs) begin
                    r_d.fld = r_q.fld + 3'd1;
                    unique case (r_q.fld)
                        FLD_SRC:  r_d.src      = mem_rdata[AW-1:0];
                        FLD_DST:  r_d.dst      = mem_rdata[AW-1:0];
                        FLD_LEN:  r_d.words    = mem_rdata[DW-1:2];
                        FLD_AADR: r_d.ack_addr = mem_rdata[AW-1:0];
                        FLD_AMSK: r_d.ack_mask = mem_rdata;
                        default: begin
                            r_d.link = mem_rdata[AW-1:0];
                            r_d.beat = '0;
                            if (r_q.words != '0) begin
                                r_d.state = ST_READ;
                                r_d.chunk = chunk_of(r_q.words);
                            end else begin
                                r_d.state = ST_ACK;
                            end
                        end
                    endcase
                end
            end
            ST_READ: begin
                if (hs) begin
                    r_d.src = r_q.src + STEP;
                    if (r_q.beat == r_q.chunk - (CW+1)'(1)) begin
                        r_d.state = ST_WRITE;
                        r_d.beat  = '0;
                    end else begin
                        r_d.beat = r_q.beat + (CW+1)'(1);
                    end
                end
            end
            ST_WRITE: begin
                if (hs) begin
                    r_d.dst   = r_q.dst + STEP;
                    r_d.words = r_q.words - LW'(1);
                    if (r_q.beat == r_q.chunk - (CW+1)'(1)) begin
                        r_d.beat = '0;
                        if (r_q.words == LW'(1)) begin
                            r_d.state = ST_ACK;
                        end else begin
                            r_d.state = ST_READ;
                            r_d.chunk = chunk_of(r_q.words - LW'(1));
                        end
                    end else begin
                        r_d.beat = r_q.beat + (CW+1)'(1);
                    end
                end
            end
            ST_ACK: begin
                if (hs) begin
                    r_d.f_node = 1'b1;
                    if (r_q.link == '0) begin
                        r_d.state   = ST_IDLE;
                        r_d.f_chain = 1'b1;
                    end else begin
                        r_d.cur   = r_q.link;
                        r_d.state = ST_WAIT;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        // abort waits for a beat boundary
        if (r_q.state != ST_IDLE) begin
            if (abort || r_q.abort_pend) begin
                if (!mem_req || mem_ready) begin
                    r_d.state      = ST_IDLE;
                    r_d.f_abort    = 1'b1;
                    r_d.abort_pend = 1'b0;
                end else begin
                    r_d.abort_pend = 1'b1;
                end
            end
        end else begin
            r_d.abort_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign irq_node  = r_q.f_node;
    assign irq_chain = r_q.f_chain;
    assign aborted   = r_q.f_abort;

endmodule

// File: rtl/dma_ll_chk.sv
`timescale 1ns/1ps
module dma_ll_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ready,
    input logic          irq_node,
    input logic          irq_chain,
    input logic          aborted,
    input logic          st_wait
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R10

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st_wait |-> !mem_req); // R6

    AST_NODE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_node) |-> $past(mem_req && mem_we && mem_ready)); // R5

    AST_CHAIN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_chain) |-> !busy); // R7

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aborted) |-> !busy); // R10
endmodule

bind dma_ll_engine dma_ll_chk #(.AW(AW)) i_dma_ll_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .irq_node  (irq_node),
    .irq_chain (irq_chain),
    .aborted   (aborted),
    .st_wait   (st_wait)
);

// File: tb/test_dma_ll_engine.sv
`timescale 1ns/1ps
module test_dma_ll_engine;
    localparam int BW  = 4;
    localparam int NT  = 8;
    localparam int SEL = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0, irq_clr = 1'b0;
    logic [31:0] head_ptr = '0;
    logic [2:0]  req_sel = 3'(SEL);
    logic [NT-1:0] trig = '0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, irq_node, irq_chain, aborted;

    logic [31:0] mem [0:1023];
    int checks = 0, errors = 0;
    int stall = 0, rc = 0;
    bit done = 0;

    bit          q_we[$];
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    dma_ll_engine #(.AW(32), .DW(32), .NTRIG(NT), .BURST_WORDS(BW)) i_dma_ll_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .irq_clr(irq_clr),
        .head_ptr(head_ptr), .req_sel(req_sel), .trig_in(trig),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .irq_node(irq_node), .irq_chain(irq_chain), .aborted(aborted));

    assign mem_rdata = mem[mem_addr[11:2]];

    // ready pattern, driven away from the clock edge
    initial begin
        mem_ready = 1'b1;
        forever begin
            @(posedge clk); #3;
            rc++;
            mem_ready = (stall != 0) ? ((rc % 3) != 1) : 1'b1;
        end
    end

    // reference beat stream compared on every clock
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            checks++;
            if (q_addr.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected beat: actual we=%b addr=%h expected no beat", mem_we, mem_addr);
            end else begin
                automatic bit          e_we = q_we.pop_front();
                automatic logic [31:0] e_ad = q_addr.pop_front();
                automatic logic [31:0] e_dt = q_data.pop_front();
                automatic string       e_tg = q_tag.pop_front();
                if (mem_we !== e_we || mem_addr !== e_ad || (e_we && mem_wdata !== e_dt)) begin
                    errors++;
                    $display("FAIL %s beat: actual we=%b addr=%h data=%h expected we=%b addr=%h data=%h",
                             e_tg, mem_we, mem_addr, mem_wdata, e_we, e_ad, e_dt);
                end
            end
            if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input bit we, input logic [31:0] a, input logic [31:0] d, input string tag);
        q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
    endtask

    task automatic set_node(input logic [31:0] p, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] len, input logic [31:0] aa, input logic [31:0] am,
                            input logic [31:0] nx);
        mem[p[11:2]]     = s;
        mem[p[11:2] + 1] = d;
        mem[p[11:2] + 2] = len;
        mem[p[11:2] + 3] = aa;
        mem[p[11:2] + 4] = am;
        mem[p[11:2] + 5] = nx;
    endtask

    // expected beats of one descriptor: fetch (R3), chunks (R4), acknowledge (R5)
    task automatic push_node(input logic [31:0] p);
        automatic logic [31:0] s = mem[p[11:2]];
        automatic logic [31:0] d = mem[p[11:2] + 1];
        automatic int          n = int'(mem[p[11:2] + 2] >> 2);
        automatic int          off = 0;
        for (int f = 0; f < 6; f++) push(1'b0, p + 32'(4 * f), '0, "R3");
        while (off < n) begin
            automatic int c = ((n - off) > BW) ? BW : (n - off);
            for (int i = 0; i < c; i++) push(1'b0, s + 32'(4 * (off + i)), '0, "R4");
            for (int i = 0; i < c; i++)
                push(1'b1, d + 32'(4 * (off + i)), mem[s[11:2] + 10'(off + i)], "R4");
            off += c;
        end
        push(1'b1, mem[p[11:2] + 3], mem[p[11:2] + 4], "R5");
    endtask

    task automatic drive_edge();
        @(posedge clk); #3;
    endtask

    task automatic pulse_start(input logic [31:0] h);
        drive_edge(); head_ptr = h; start = 1'b1;
        drive_edge(); start = 1'b0;
    endtask

    task automatic pulse_abort();
        drive_edge(); abort = 1'b1;
        drive_edge(); abort = 1'b0;
    endtask

    task automatic pulse_clr();
        drive_edge(); irq_clr = 1'b1;
        drive_edge(); irq_clr = 1'b0;
    endtask

    task automatic pulse_trig(input int idx);
        drive_edge(); trig[idx] = 1'b1;
        drive_edge(); trig[idx] = 1'b0;
    endtask

    task automatic wait_quiet(input int n, input string tag);
        automatic int bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (mem_req) bad++;
        end
        check(bad == 0, tag, "cycles with a request", 32'(bad), 32'd0);
    endtask

    task automatic wait_idle(input string tag);
        automatic int t = 0;
        do begin @(negedge clk); t++; end while (busy && t < 3000);
        check(!busy, tag, "busy after chain", 32'(busy), 32'd0);
    endtask

    task automatic wait_drain(input string tag);
        automatic int t = 0;
        do begin @(negedge clk); t++; end while (q_addr.size() != 0 && t < 3000);
        check(q_addr.size() == 0, tag, "beats still expected", 32'(q_addr.size()), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h5A5A_0000 ^ 32'(i);
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(!busy && !mem_req, "R1", "busy/req after reset", {30'd0, busy, mem_req}, 32'd0);
        check(!irq_node && !irq_chain && !aborted, "R1", "flags after reset",
              {29'd0, irq_node, irq_chain, aborted}, 32'd0);

        // single node, 41 bytes -> 10 words in chunks 4,4,2 (R4), zero link (R7)
        set_node(32'h100, 32'h400, 32'h800, 32'd41, 32'hF00, 32'h20, 32'h0);
        push_node(32'h100);
        pulse_start(32'h100);
        wait_quiet(8, "R2");
        pulse_trig(2);
        wait_quiet(8, "R2");
        check(busy, "R2", "busy while waiting", 32'(busy), 32'd1);
        pulse_trig(SEL);
        wait_idle("R7");
        check(irq_chain && irq_node, "R7", "chain/node flags", {30'd0, irq_chain, irq_node}, 32'd3);
        check(!aborted, "R7", "aborted flag", 32'(aborted), 32'd0);
        check(q_addr.size() == 0, "R4", "beats left", 32'(q_addr.size()), 32'd0);
        for (int i = 0; i < 10; i++)
            check(mem[10'h200 + 10'(i)] == mem[10'h100 + 10'(i)], "R4", "destination word",
                  mem[10'h200 + 10'(i)], mem[10'h100 + 10'(i)]);
        check(mem[10'h20A] == (32'h5A5A_0000 ^ 32'h20A), "R4", "word past block",
              mem[10'h20A], 32'h5A5A_0000 ^ 32'h20A);
        check(mem[10'h3C0] == 32'h20, "R5", "acknowledge word", mem[10'h3C0], 32'h20);

        // R12: clear of node and chain flags
        pulse_clr();
        @(negedge clk);
        check(!irq_node && !irq_chain, "R12", "flags after clear", {30'd0, irq_node, irq_chain}, 32'd0);

        // pending trigger (R9) and zero-length node (R11), memory stalls
        stall = 1;
        set_node(32'h140, 32'h480, 32'h900, 32'd24, 32'hF04, 32'h1, 32'h180);
        set_node(32'h180, 32'h0, 32'h0, 32'd3, 32'hF08, 32'h2, 32'h0);
        push_node(32'h140);
        push_node(32'h180);
        pulse_start(32'h140);
        pulse_trig(SEL);
        repeat (4) @(posedge clk);
        pulse_trig(SEL);
        wait_idle("R9");
        check(q_addr.size() == 0, "R9", "beats left", 32'(q_addr.size()), 32'd0);
        check(irq_chain, "R9", "chain flag", 32'(irq_chain), 32'd1);
        check(mem[10'h3C2] == 32'h2, "R11", "acknowledge of empty node", mem[10'h3C2], 32'h2);

        // R6: parked between nodes until the next trigger
        set_node(32'h1C0, 32'h500, 32'hA00, 32'd8, 32'hF0C, 32'h4, 32'h200);
        set_node(32'h200, 32'h520, 32'hA40, 32'd4, 32'hF10, 32'h8, 32'h0);
        push_node(32'h1C0);
        pulse_start(32'h1C0);
        pulse_trig(SEL);
        wait_drain("R6");
        wait_quiet(20, "R6");
        check(busy && irq_node && !irq_chain, "R6", "busy/node/chain while parked",
              {29'd0, busy, irq_node, irq_chain}, 32'h6);
        push_node(32'h200);
        pulse_trig(SEL);
        wait_idle("R6");
        check(q_addr.size() == 0 && irq_chain, "R6", "second node done", 32'(q_addr.size()), 32'd0);

        // R8: circular chain, then R10: abort in the middle of a node
        set_node(32'h240, 32'h540, 32'hB00, 32'd20, 32'hF14, 32'h10, 32'h280);
        set_node(32'h280, 32'h560, 32'hB40, 32'd12, 32'hF18, 32'h20, 32'h240);
        pulse_start(32'h240);
        for (int k = 0; k < 4; k++) begin
            push_node((k % 2 == 0) ? 32'h240 : 32'h280);
            pulse_trig(SEL);
            wait_drain("R8");
            repeat (3) @(posedge clk);
        end
        @(negedge clk);
        check(busy && !irq_chain, "R8", "busy/chain after looping", {30'd0, busy, irq_chain}, 32'h2);
        push_node(32'h240);
        pulse_trig(SEL);
        repeat (8) @(posedge clk);
        pulse_abort();
        repeat (3) @(negedge clk);
        check(!busy && aborted, "R10", "busy/aborted after abort", {30'd0, busy, aborted}, 32'h1);
        q_we.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
        wait_quiet(15, "R10");

        // R12: start clears aborted; abort while parked stops at once
        pulse_start(32'h240);
        @(negedge clk);
        check(!aborted && busy, "R12", "aborted/busy after start", {30'd0, aborted, busy}, 32'h1);
        pulse_abort();
        @(negedge clk);
        check(!busy && aborted, "R10", "abort while waiting", {30'd0, busy, aborted}, 32'h1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule